// File: doc/BRIEF.md
# Two-Wire Paired-Bit Serial Transmitter

This block is the peripheral-side sender for a fast byte stream to a single host over two open-collector lines, here called DATA and CLOCK. Each line has a drive-low enable output. When a byte is waiting, the block runs a short opening handshake with the host. It then marks time zero with one sync pulse on both lines.

After the sync pulse the block owns both lines. Each line carries one data bit per slot, so each byte goes out as four bit pairs. There is no strobe. The receiver keeps alignment by counting time from the sync pulse, so every timing distance is fixed.

All timing is counted in cycle-ticks, which come from the `tick_i` enable. Bytes enter through a valid/ready handshake. A byte is taken only at the moment its first slot is due. If no byte is valid at that moment, the transfer ends.

Top module: `pb_pair_tx`

## Requirements
- R1: After reset, and in idle, both drive-low enables are off and `ready_o` is low. When `valid_i` is high in idle, the block drives DATA low at a tick. It keeps DATA low, without driving CLOCK, until it senses CLOCK low.
- R2: On the first tick that senses CLOCK low, the block releases DATA. It then keeps both lines released until a tick senses CLOCK high again.
- R3: On the tick that senses CLOCK high, the block drives both lines low together. On the very next tick it releases both together; this is the sync pulse.
- R4: The first pair slot of a transfer comes 8 ticks after the sync release. Within a byte, each pair is placed 8 ticks after the one before it.
- R5: Pairs go out in the order (bit1, bit3), (bit0, bit2), (bit5, bit7), (bit4, bit6). The lower-numbered bit of a pair goes on DATA and the higher one on CLOCK. A 1 releases the line, and a 0 drives it low.
- R6: The first pair of the next byte comes 22 ticks after the last pair of the previous byte.
- R7: `ready_o` is high only in a cycle with `tick_i` high at which a byte's first slot is due. If `valid_i` is low then, the block releases both lines at that tick and returns to idle.
- R8: The drive-low outputs change only at clock edges where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Cycle-tick enable; all timing counts these |
| byte_i | input | 8 | Byte offered for sending |
| valid_i | input | 1 | `byte_i` is valid; in idle, starts a transfer |
| ready_o | output | 1 | Byte taken at this edge |
| data_lo_o | output | 1 | Drive DATA line low |
| clock_lo_o | output | 1 | Drive CLOCK line low |
| clock_sense_i | input | 1 | Sensed level of the CLOCK line |

## Verification
A host model keeps CLOCK low well past the point where DATA has been released. A sender that treated the first CLOCK change as the cue, rather than the CLOCK release, would fire its sync pulse early, while the host still holds the line.

Ticks arrive on an irregular clock pattern. A design that counted clocks instead of ticks, or that placed a byte 21 or 23 ticks after the previous one, would show a level change where the bench expects stable lines. Bytes 0x00, 0xFF, 0xA5 and 0x3C expose a swapped pair order or swapped line mapping.

Ending each burst by dropping `valid_i` checks that the lines are released at the missing slot, and not left holding the last pair.

// File: rtl/pb_pair_tx_pkg.sv
package pb_pair_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_ACK, ST_SYNC, ST_LEAD, ST_SEND
  } tx_state_e;
endpackage

// File: rtl/pb_tick_timer.sv
module pb_tick_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pb_pair_sel.sv
module pb_pair_sel (
  input  logic [7:0] byte_i,
  input  logic [1:0] idx_i,
  output logic       data_bit_o,
  output logic       clock_bit_o
);
  // pair order 1/3, 0/2, 5/7, 4/6: low bit index = {idx[1], 0, ~idx[0]}
  logic [2:0] lo_idx, hi_idx;
  assign lo_idx      = {idx_i[1], 1'b0, ~idx_i[0]};
  assign hi_idx      = {idx_i[1], 1'b1, ~idx_i[0]};
  assign data_bit_o  = byte_i[lo_idx];
  assign clock_bit_o = byte_i[hi_idx];
endmodule

// File: rtl/pb_pair_tx.sv
module pb_pair_tx #(
  parameter int unsigned PAIR_TICKS = 8,
  parameter int unsigned GAP_TICKS  = 22,
  parameter int unsigned LEAD_TICKS = 8,
  parameter int unsigned SYNC_TICKS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] byte_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       data_lo_o,
  output logic       clock_lo_o,
  input  logic       clock_sense_i
);
  import pb_pair_tx_pkg::*;

  localparam int unsigned MAX_T = (GAP_TICKS > PAIR_TICKS) ?
                                  ((GAP_TICKS > LEAD_TICKS) ? GAP_TICKS : LEAD_TICKS) :
                                  ((PAIR_TICKS > LEAD_TICKS) ? PAIR_TICKS : LEAD_TICKS);
  localparam int unsigned CW = $clog2(MAX_T + 1);
  localparam logic [CW-1:0] PAIR_LD = CW'(PAIR_TICKS - 1);
  localparam logic [CW-1:0] GAP_LD  = CW'(GAP_TICKS - 1);
  localparam logic [CW-1:0] LEAD_LD = CW'(LEAD_TICKS - 1);
  localparam logic [CW-1:0] SYNC_LD = CW'(SYNC_TICKS - 1);

  tx_state_e     state_q;
  logic [1:0]    idx_q, nxt_idx;
  logic [7:0]    byte_q, sel_byte;
  logic          expired, slot_due, byte_slot;
  logic          load;
  logic [CW-1:0] load_val;
  logic          pair_d, pair_c;

  pb_tick_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  assign slot_due  = tick_i && expired &&
                     (state_q == ST_LEAD || state_q == ST_SEND);
  assign byte_slot = (state_q == ST_LEAD) || (idx_q == 2'd3);
  assign ready_o   = slot_due && byte_slot;
  assign nxt_idx   = byte_slot ? 2'd0 : idx_q + 2'd1;
  assign sel_byte  = byte_slot ? byte_i : byte_q;

  pb_pair_sel u_sel (
    .byte_i      (sel_byte),
    .idx_i       (nxt_idx),
    .data_bit_o  (pair_d),
    .clock_bit_o (pair_c)
  );

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    if (tick_i) begin
      unique case (state_q)
        ST_ACK: if (clock_sense_i) begin
          load = 1'b1; load_val = SYNC_LD;
        end
        ST_SYNC: if (expired) begin
          load = 1'b1; load_val = LEAD_LD;
        end
        ST_LEAD, ST_SEND: if (expired && (!byte_slot || valid_i)) begin
          load     = 1'b1;
          load_val = (nxt_idx == 2'd3) ? GAP_LD : PAIR_LD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      byte_q     <= '0;
      data_lo_o  <= 1'b0;
      clock_lo_o <= 1'b0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: if (valid_i) begin
          state_q   <= ST_REQ;
          data_lo_o <= 1'b1;
        end
        ST_REQ: if (!clock_sense_i) begin
          state_q   <= ST_ACK;
          data_lo_o <= 1'b0;
        end
        ST_ACK: if (clock_sense_i) begin
          state_q    <= ST_SYNC;
          data_lo_o  <= 1'b1;
          clock_lo_o <= 1'b1;
        end
        ST_SYNC: if (expired) begin
          state_q    <= ST_LEAD;
          data_lo_o  <= 1'b0;
          clock_lo_o <= 1'b0;
        end
        ST_LEAD, ST_SEND: if (expired) begin
          if (byte_slot && !valid_i) begin
            state_q    <= ST_IDLE;
            data_lo_o  <= 1'b0;
            clock_lo_o <= 1'b0;
          end else begin
            state_q    <= ST_SEND;
            idx_q      <= nxt_idx;
            if (byte_slot) byte_q <= byte_i;
            data_lo_o  <= ~pair_d;
            clock_lo_o <= ~pair_c;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pb_pair_tx_chk.sv
module pb_pair_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [7:0] byte_i,
  input logic       valid_i,
  input logic       ready_o,
  input logic       data_lo_o,
  input logic       clock_lo_o,
  input logic       clock_sense_i
);
  logic [7:0] unused_byte;
  assign unused_byte = byte_i;

  assert_ready_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> tick_i);

  assert_end_releases_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> (!data_lo_o && !clock_lo_o));

  assert_hold_off_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(data_lo_o) && $stable(clock_lo_o)));

  assert_ack_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && data_lo_o && !clock_lo_o && !clock_sense_i) |=> !data_lo_o);
endmodule

bind pb_pair_tx pb_pair_tx_chk u_chk (.*);

// File: tb/pb_pair_tx_tb_top.sv
module pb_pair_tx_tb_top;
  localparam int FIRST = 8;
  localparam int PAIR  = 8;
  localparam int STRIDE = 3 * 8 + 22;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic valid_i = 1'b0;
  logic ready_o, data_lo_o, clock_lo_o, clock_sense_i;
  logic host_clk = 1'b0;

  int total = 0, bad = 0, cyc = 0, done_cnt = 0;
  bit xfer_active = 1'b0;
  bit rst_done = 1'b0;
  logic [7:0] exp_q[$];

  assign clock_sense_i = !(clock_lo_o || host_clk);

  always #10 clk_i = ~clk_i;

  pb_pair_tx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .byte_i(byte_i),
    .valid_i(valid_i), .ready_o(ready_o), .data_lo_o(data_lo_o),
    .clock_lo_o(clock_lo_o), .clock_sense_i(clock_sense_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor and tick generator share one block: tick value here is the one the last edge used
  int mon_st = 0, t = 0, nb = 0;
  logic [7:0] cur = '0;
  logic pd = 1'b0, pc = 1'b0, pdl = 1'b0, pcl = 1'b0;
  always @(negedge clk_i) begin
    if (rst_done) begin
      logic dl, cl;
      int off, lo;
      dl = !data_lo_o;
      cl = !(clock_lo_o || host_clk);
      if (!tick_i) begin
        check(data_lo_o == pdl && clock_lo_o == pcl, "R8", {data_lo_o, clock_lo_o}, {pdl, pcl});
      end else begin
        case (mon_st)
          0: if (xfer_active && !dl && !cl) mon_st = 1;
          1: begin
            check(dl && cl, "R3", {dl, cl}, 2'b11);
            t = 0; nb = 0; mon_st = 2;
          end
          default: begin
            t++;
            off = t - (FIRST + STRIDE * nb);
            if (off == 0) begin
              if (exp_q.size() > 0) begin
                cur = exp_q.pop_front();
                check(dl == cur[1] && cl == cur[3], "R5", {dl, cl}, {cur[1], cur[3]});
              end else begin
                check(dl && cl, "R7", {dl, cl}, 2'b11);
                mon_st = 0; xfer_active = 1'b0; done_cnt++;
              end
            end else if (off == PAIR || off == 2 * PAIR || off == 3 * PAIR) begin
              lo = (off == PAIR) ? 0 : (off == 2 * PAIR) ? 5 : 4;
              check(dl == cur[lo] && cl == cur[lo + 2], "R5", {dl, cl}, {cur[lo], cur[lo + 2]});
              if (off == 3 * PAIR) nb++;
            end else begin
              check(dl == pd && cl == pc, (off < 0 || nb == 0) ? "R6" : "R4", {dl, cl}, {pd, pc});
            end
          end
        endcase
        pd = dl; pc = cl;
      end
      pdl = data_lo_o; pcl = clock_lo_o;
    end
    cyc++;
    tick_i = (cyc % 3) != 0;
  end

  // host model: acknowledges the opening request, then lets the sender own the lines
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_done && !xfer_active && data_lo_o) begin
        bit ok;
        ok = 1'b1;
        repeat (20) begin
          @(negedge clk_i);
          if (!(data_lo_o && !clock_lo_o)) ok = 1'b0;
        end
        check(ok, "R1", {data_lo_o, clock_lo_o}, 2'b10);
        host_clk = 1'b1;
        repeat (12) @(negedge clk_i);
        check(!data_lo_o, "R2", data_lo_o, 0);
        ok = 1'b1;
        repeat (10) begin
          @(negedge clk_i);
          if (data_lo_o || clock_lo_o) ok = 1'b0;
        end
        check(ok, "R2", {data_lo_o, clock_lo_o}, 0);
        xfer_active = 1'b1;
        host_clk = 1'b0;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    valid_i = 1'b1;
    byte_i  = b;
    forever begin
      @(posedge clk_i);
      if (ready_o && valid_i) break;
    end
    check(tick_i, "R7", tick_i, 1);
    exp_q.push_back(b);
    @(negedge clk_i);
  endtask

  task automatic burst(input logic [7:0] bytes[$]);
    int target;
    target = done_cnt + 1;
    foreach (bytes[i]) send_byte(bytes[i]);
    valid_i = 1'b0;
    wait (done_cnt == target);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!data_lo_o && !clock_lo_o && !ready_o, "R1", {data_lo_o, clock_lo_o, ready_o}, 0);
    pdl = data_lo_o; pcl = clock_lo_o;
    rst_done = 1'b1;
    burst('{8'hA5, 8'h3C, 8'h00, 8'hFF});
    repeat (30) @(negedge clk_i);
    check(!data_lo_o && !clock_lo_o, "R7", {data_lo_o, clock_lo_o}, 0);
    burst('{8'h81});
    repeat (7) @(negedge clk_i);
    burst('{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hEF});
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule